// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit watches an active-low external interrupt pin and turns its activity into a request that a small 8-bit processor core can take. A control register bit chooses the sensing rule at run time. With the bit set, only a falling edge counts. With the bit clear, a falling edge or a held low level counts. A single edge latch remembers one falling edge. The request is gated by an interrupt mask flag that the unit keeps for the core. Taking a request sets that flag again.

The request to the core is a valid/ready pair. `req_valid` stays high for as long as a pending request is unmasked. The core takes the request by raising `req_ready` in a cycle where `req_valid` is high, and that cycle is the start of servicing. `req_valid` never waits on `req_ready`, and a request that is not taken stays pending, so the core can hold off for any number of cycles and lose nothing.

A software-interrupt instruction is signalled on `swi_valid`. It is always taken, whatever the mask. While it is signalled it takes precedence over the external request. `vec_addr` gives the address of the high vector byte for the interrupt being taken; the low byte sits at the next address. Software reaches the control register through a byte-wide write/read port.

Top module: `xint_ctrl`

## Requirements
- R1: When control bit 3 is 1 (edge mode), only a falling edge on `irq_pin_n` raises a request. A pin held low after that request has been taken raises no further request.
- R2: When control bit 3 is 0 (level mode), a low pin level or a falling edge raises a request.
- R3: `req_valid` is high only while `imask` is 0.
- R4: A cycle with `req_valid` and `req_ready` both high sets `imask` from the next cycle and clears the edge latch. A falling edge seen in that same cycle is kept pending.
- R5: `swi_valid` is taken whatever the state of `imask`. In that cycle `vec_addr` is 16'hFFFC, and `imask` is 1 from the next cycle.
- R6: When `swi_valid` is low, `vec_addr` is 16'hFFF8.
- R7: While `imask` is 1, any number of falling edges leave exactly one request pending. That request is presented once `imask` is cleared.
- R8: In level mode, if the pin is still low after a request has been taken and `imask` is cleared, `req_valid` rises again.
- R9: While `swi_valid` is high, `req_valid` is low. A pending external edge is kept and is presented after the mask is cleared.
- R10: The control register is at address 8'h1C and resets to 8'h03, so the unit starts in level mode. All eight written bits read back unchanged on `reg_rdata`. Any other address reads 8'h00.
- R11: The pin passes through a two-flop synchronizer. In level mode, a low pin shows on `req_valid` at the third check point after the pin falls. In edge mode it shows at the fourth.
- R12: `mask_set` sets `imask` and `mask_clr` clears it, from the next cycle. When both are high, set wins. `imask` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Active-low external interrupt pin, asynchronous |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| req_valid | output | 1 | External interrupt request to the core |
| req_ready | input | 1 | Core takes the request (start of servicing) |
| swi_valid | input | 1 | Software-interrupt instruction being taken |
| mask_set | input | 1 | Core sets the interrupt mask |
| mask_clr | input | 1 | Core clears the interrupt mask (CLI or return from interrupt) |
| imask | output | 1 | Current interrupt mask flag |
| vec_addr | output | 16 | Address of the high vector byte |

## Verification
Some rules are checked by assertions on every cycle:
- a taken request or a software interrupt sets the mask in the next cycle;
- `req_valid` stays low while a software interrupt is signalled;
- the mask never rises without a cause.

Other behaviour needs a history of pin activity, so only the bench scenarios can show it:
- edge mode ignores a pin that stays low;
- several edges during service collapse into one pending request;
- level mode raises the request again after service;
- the synchronizer delay;
- the register reset value and read-back.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned VEC_W       = 16;
  localparam logic [7:0]  CTRL_ADDR   = 8'h1C;
  localparam logic [7:0]  CTRL_RESET  = 8'h03;
  localparam int unsigned SENSE_BIT   = 3;
  localparam logic [15:0] VEC_EXT     = 16'hFFF8;
  localparam logic [15:0] VEC_SWI     = 16'hFFFC;

  typedef enum logic {SENSE_LEVEL = 1'b0, SENSE_EDGE = 1'b1} sense_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_lvl,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              smp;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign smp = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= smp;
  end

  assign low_lvl = ~smp;
  assign fall    = prev & ~smp;
endmodule

// File: rtl/xint_ctrlreg.sv
module xint_ctrlreg #(
  parameter int unsigned    DW        = 8,
  parameter int unsigned    AW        = 8,
  parameter logic [AW-1:0]  ADDR      = 8'h1C,
  parameter logic [DW-1:0]  RST_VAL   = 8'h03,
  parameter int unsigned    SEL_BIT   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic          edge_only
);
  logic [DW-1:0] ctrl_q;
  logic          hit;

  assign hit = (addr == ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= RST_VAL;
    else if (we && hit) ctrl_q <= wdata;
  end

  assign rdata     = hit ? ctrl_q : '0;
  assign edge_only = ctrl_q[SEL_BIT];
endmodule

// File: rtl/xint_arb.sv
module xint_arb #(
  parameter int unsigned    VW      = 16,
  parameter logic [VW-1:0]  V_EXT   = 16'hFFF8,
  parameter logic [VW-1:0]  V_SWI   = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          low_lvl,
  input  logic          edge_only,
  input  logic          req_ready,
  input  logic          swi_valid,
  input  logic          mask_set,
  input  logic          mask_clr,
  output logic          req_valid,
  output logic          imask,
  output logic [VW-1:0] vec_addr
);
  logic latch_q;
  logic mask_q;
  logic pending;
  logic take;

  // Edge mode looks only at the latch; level mode also sees a low pin.
  assign pending   = latch_q | (~edge_only & low_lvl);
  assign req_valid = pending & ~mask_q & ~swi_valid;
  assign take      = req_valid & req_ready;

  // A new edge beats the clear, so an edge in the take cycle stays pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_q <= 1'b0;
    else if (fall) latch_q <= 1'b1;
    else if (take) latch_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mask_q <= 1'b1;
    else if (take || swi_valid || mask_set) mask_q <= 1'b1;
    else if (mask_clr)                      mask_q <= 1'b0;
  end

  assign imask    = mask_q;
  assign vec_addr = swi_valid ? V_SWI : V_EXT;
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned    DW          = BYTE_W,
  parameter int unsigned    AW          = 8,
  parameter int unsigned    VW          = VEC_W,
  parameter int unsigned    SYNC_STAGES = 2,
  parameter logic [AW-1:0]  REG_ADDR    = CTRL_ADDR,
  parameter logic [DW-1:0]  REG_RST     = CTRL_RESET,
  parameter int unsigned    SEL_BIT     = SENSE_BIT,
  parameter logic [VW-1:0]  EXT_VEC     = VEC_EXT,
  parameter logic [VW-1:0]  SWI_VEC     = VEC_SWI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pin_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  input  logic          swi_valid,
  input  logic          mask_set,
  input  logic          mask_clr,
  output logic          imask,
  output logic [VW-1:0] vec_addr
);
  logic low_lvl;
  logic fall;
  logic edge_only;

  xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (irq_pin_n),
    .low_lvl (low_lvl),
    .fall    (fall)
  );

  xint_ctrlreg #(
    .DW(DW), .AW(AW), .ADDR(REG_ADDR), .RST_VAL(REG_RST), .SEL_BIT(SEL_BIT)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .we        (reg_we),
    .rdata     (reg_rdata),
    .edge_only (edge_only)
  );

  xint_arb #(.VW(VW), .V_EXT(EXT_VEC), .V_SWI(SWI_VEC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .low_lvl   (low_lvl),
    .edge_only (edge_only),
    .req_ready (req_ready),
    .swi_valid (swi_valid),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .req_valid (req_valid),
    .imask     (imask),
    .vec_addr  (vec_addr)
  );
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic swi_valid,
  input logic mask_set,
  input logic imask
);
  AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> imask); // R4
  AST_SWI_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    swi_valid |=> imask); // R5
  AST_SWI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    swi_valid |-> !req_valid); // R9
  AST_MASK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imask) |-> $past((req_valid && req_ready) || swi_valid || mask_set)); // R12
endmodule

bind xint_ctrl xint_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .swi_valid (swi_valid),
  .mask_set  (mask_set),
  .imask     (imask)
);

// File: tb/xint_ctrl_test.sv
`timescale 1ns/1ps
module xint_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_pin_n = 1'b1;
  logic [7:0]  reg_addr = 8'h1C;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        swi_valid = 1'b0;
  logic        mask_set = 1'b0;
  logic        mask_clr = 1'b0;
  logic        imask;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .swi_valid(swi_valid),
    .mask_set(mask_set), .mask_clr(mask_clr), .imask(imask), .vec_addr(vec_addr)
  );

  // entry: [21]pin [20]ready [19]swi [18]mclr [17]exp_valid [16]exp_imask [15:0]exp_vec
  localparam int NV = 12;
  localparam logic [21:0] TBL [NV] = '{
    {4'b1001, 2'b01, 16'hFFF8},  // R12 clear mask
    {4'b0000, 2'b00, 16'hFFF8},  // pin falls
    {4'b0000, 2'b00, 16'hFFF8},  // R11 not yet through sync
    {4'b0000, 2'b10, 16'hFFF8},  // R2 R11 level request
    {4'b0100, 2'b10, 16'hFFF8},  // R4 taken
    {4'b0001, 2'b01, 16'hFFF8},  // R3 masked
    {4'b0000, 2'b10, 16'hFFF8},  // R8 pin still low, request again
    {4'b1100, 2'b10, 16'hFFF8},  // take it
    {4'b1001, 2'b01, 16'hFFF8},  // R12 clear mask
    {4'b1000, 2'b00, 16'hFFF8},  // pin high, nothing pending
    {4'b1010, 2'b00, 16'hFFFC},  // R5 software interrupt, mask clear
    {4'b1000, 2'b01, 16'hFFF8}   // R5 R6 mask set by software interrupt
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, check just before the next rising edge.
  task automatic cyc(input logic p, input logic r, input logic s, input logic ms, input logic mc);
    @(negedge clk);
    irq_pin_n = p; req_ready = r; swi_valid = s; mask_set = ms; mask_clr = mc;
    #1;
  endtask

  task automatic idle(input logic p, input int n);
    for (int i = 0; i < n; i++) cyc(p, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h1C;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // reset state
    chk("R10 reset reg", {8'h00, reg_rdata}, 16'h0003);
    chk("R12 reset mask", {15'd0, imask}, 16'd1);
    chk("R3 reset valid", {15'd0, req_valid}, 16'd0);
    chk("R6 reset vec", vec_addr, 16'hFFF8);

    for (int k = 0; k < NV; k++) begin
      cyc(TBL[k][21], TBL[k][20], TBL[k][19], 1'b0, TBL[k][18]);
      chk($sformatf("table %0d valid", k), {15'd0, req_valid}, {15'd0, TBL[k][17]});
      chk($sformatf("table %0d imask", k), {15'd0, imask}, {15'd0, TBL[k][16]});
      chk($sformatf("table %0d vec", k), vec_addr, TBL[k][15:0]);
    end

    // R10 register read-back and decode
    wr(8'h1C, 8'hA5);
    chk("R10 readback A5", {8'h00, reg_rdata}, 16'h00A5);
    reg_addr = 8'h1D; #1;
    chk("R10 other address", {8'h00, reg_rdata}, 16'h0000);
    reg_addr = 8'h1C;
    wr(8'h1C, 8'hFC);
    chk("R10 readback FC", {8'h00, reg_rdata}, 16'h00FC);

    // R12 set wins over clear
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1'b1, 1);
    chk("R12 set wins", {15'd0, imask}, 16'd1);

    // R1 / R11 edge mode
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1'b0, 3);
    chk("R11 edge mode not yet", {15'd0, req_valid}, 16'd0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 edge request", {15'd0, req_valid}, 16'd1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 mask after take", {15'd0, imask}, 16'd1);
    idle(1'b0, 1);
    chk("R1 low level ignored", {15'd0, req_valid}, 16'd0);
    idle(1'b0, 2);
    chk("R1 still ignored", {15'd0, req_valid}, 16'd0);

    // R7 one pending edge during service
    idle(1'b1, 3);
    idle(1'b0, 3);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 first request", {15'd0, req_valid}, 16'd1);
    idle(1'b1, 3); idle(1'b0, 3); idle(1'b1, 3); idle(1'b0, 3); idle(1'b1, 3);
    chk("R3 masked while edges", {15'd0, req_valid}, 16'd0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 one held edge", {15'd0, req_valid}, 16'd1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1'b1, 1);
    chk("R7 only one", {15'd0, req_valid}, 16'd0);

    // R9 software interrupt beats pending edge
    idle(1'b0, 3);
    idle(1'b0, 1);
    chk("R9 edge pending", {15'd0, req_valid}, 16'd1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 valid low under swi", {15'd0, req_valid}, 16'd0);
    chk("R5 swi vector", vec_addr, 16'hFFFC);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 mask after swi", {15'd0, imask}, 16'd1);
    idle(1'b0, 1);
    chk("R9 edge kept", {15'd0, req_valid}, 16'd1);
    chk("R6 ext vector", vec_addr, 16'hFFF8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule